// File: doc/BRIEF.md
# Predicated Vector OR Reduction Unit

This block collapses one wide vector operand into a single scalar by taking the bitwise OR of its elements. A governing predicate decides which elements take part. The element width is chosen per operation by a 2-bit size code and can be 8, 16, 32 or 64 bits. The vector length `VL` is a synthesis parameter and must be a multiple of 128 bits.

The predicate carries one bit per byte of the vector. An element is enabled by the predicate bit that sits at its lowest byte. A disabled element contributes nothing to the result.

The scalar result comes back on a 64-bit port, right-aligned at the selected element width. Each input strobe produces one output strobe on the next clock. That latency does not change with the data, the predicate or the size.

Top module: `orv_reduce`

## Requirements
- R1: The size code `size_i` sets the element width to 8 << `size_i`. Code 0 gives 8 bits, 1 gives 16, 2 gives 32 and 3 gives 64. The number of elements reduced is VL divided by that width.
- R2: Element e is active exactly when predicate bit e*(width/8) is 1. The other predicate bits within that element's bytes have no effect on the result.
- R3: The result is the bitwise OR, at full element width, of all active elements, starting from zero. Inactive elements contribute zero.
- R4: When no element is active, the result is all zeros.
- R5: The result sits in bits [width-1:0] of `res_o`. Every bit of `res_o` above the element width is 0.
- R6: `vld_o` is 1 in the cycle that follows each cycle in which `vld_i` is 1, and 0 otherwise. The result for that input appears with it, for every size, predicate and data value.
- R7: A synchronous active-high `rst` drives `vld_o` and `res_o` to zero on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| vld_i | input | 1 | Operation request strobe |
| vec_i | input | VL | Vector operand |
| pred_i | input | VL/8 | Governing predicate, one bit per byte |
| size_i | input | 2 | Element size code |
| vld_o | output | 1 | Result valid strobe |
| res_o | output | 64 | Scalar OR result, zero-extended |

## Verification
The assertions take the size code and the strobe as known values in every clocked cycle outside reset. They also assume `rst` is held high from the first edge, so the output register starts from a defined state. The stimulus drives every input on the falling edge from a defined value and holds reset for several cycles first. Random trials draw predicates with both dense and sparse bit patterns, so that all-inactive, single-element and full-vector cases all occur. Directed cases also set only the non-leading predicate bits of each element.

// File: rtl/orv_pkg.sv
package orv_pkg;
  localparam int unsigned RES_W  = 64;
  localparam int unsigned LANE_W = 8;
  localparam int unsigned LANES_PER_RES = RES_W / LANE_W;

  typedef enum logic [1:0] {
    ESZ_8  = 2'd0,
    ESZ_16 = 2'd1,
    ESZ_32 = 2'd2,
    ESZ_64 = 2'd3
  } esz_e;
endpackage

// File: rtl/orv_lane_gate.sv
// Zeroes every byte lane whose owning element is inactive.
// The owning element's leading byte index is the lane index with its low size bits cleared.
module orv_lane_gate
  import orv_pkg::*;
#(
  parameter int unsigned VL = 256,
  localparam int unsigned NBYTE = VL / LANE_W
) (
  input  logic [VL-1:0]    vec_i,
  input  logic [NBYTE-1:0] pred_i,
  input  logic [1:0]       size_i,
  output logic [VL-1:0]    gated_o
);
  for (genvar b = 0; b < NBYTE; b++) begin : g_lane
    localparam int unsigned LEAD8  = b;
    localparam int unsigned LEAD16 = b & ~32'd1;
    localparam int unsigned LEAD32 = b & ~32'd3;
    localparam int unsigned LEAD64 = b & ~32'd7;
    logic act;
    always_comb begin
      case (esz_e'(size_i))
        ESZ_8:   act = pred_i[LEAD8];
        ESZ_16:  act = pred_i[LEAD16];
        ESZ_32:  act = pred_i[LEAD32];
        default: act = pred_i[LEAD64];
      endcase
    end
    assign gated_o[b*LANE_W +: LANE_W] = act ? vec_i[b*LANE_W +: LANE_W] : '0;
  end
endmodule

// File: rtl/orv_or_tree.sv
// Balanced OR tree across the 64-bit slices of the gated vector.
// Elements are naturally aligned, so lane positions are preserved.
module orv_or_tree
  import orv_pkg::*;
#(
  parameter int unsigned VL = 256,
  localparam int unsigned NSLICE = VL / RES_W,
  localparam int unsigned DEPTH  = (NSLICE > 1) ? $clog2(NSLICE) : 1,
  localparam int unsigned NLEAF  = 1 << DEPTH
) (
  input  logic [VL-1:0]    gated_i,
  output logic [RES_W-1:0] acc_o
);
  logic [RES_W-1:0] node [1:2*NLEAF-1];

  for (genvar l = 0; l < NLEAF; l++) begin : g_leaf
    if (l < NSLICE) begin : g_used
      assign node[NLEAF+l] = gated_i[l*RES_W +: RES_W];
    end else begin : g_pad
      assign node[NLEAF+l] = '0;
    end
  end

  for (genvar i = 1; i < NLEAF; i++) begin : g_inner
    assign node[i] = node[2*i] | node[2*i+1];
  end

  assign acc_o = node[1];
endmodule

// File: rtl/orv_fold.sv
// Folds the 64-bit accumulation down to the selected element width and clears the bits above it.
module orv_fold
  import orv_pkg::*;
(
  input  logic [RES_W-1:0] acc_i,
  input  logic [1:0]       size_i,
  output logic [RES_W-1:0] res_o
);
  logic [31:0] f32;
  logic [15:0] f16;
  logic [7:0]  f8;

  assign f32 = acc_i[31:0] | acc_i[63:32];
  assign f16 = f32[15:0] | f32[31:16];
  assign f8  = f16[7:0] | f16[15:8];

  always_comb begin
    case (esz_e'(size_i))
      ESZ_8:   res_o = {56'd0, f8};
      ESZ_16:  res_o = {48'd0, f16};
      ESZ_32:  res_o = {32'd0, f32};
      default: res_o = acc_i;
    endcase
  end
endmodule

// File: rtl/orv_reduce.sv
module orv_reduce
  import orv_pkg::*;
#(
  parameter int unsigned VL = 256,
  localparam int unsigned NBYTE = VL / LANE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vld_i,
  input  logic [VL-1:0]    vec_i,
  input  logic [NBYTE-1:0] pred_i,
  input  logic [1:0]       size_i,
  output logic             vld_o,
  output logic [RES_W-1:0] res_o
);
  logic [VL-1:0]    gated;
  logic [RES_W-1:0] acc;
  logic [RES_W-1:0] folded;

  orv_lane_gate #(.VL(VL)) u_gate (
    .vec_i  (vec_i),
    .pred_i (pred_i),
    .size_i (size_i),
    .gated_o(gated)
  );

  orv_or_tree #(.VL(VL)) u_tree (
    .gated_i(gated),
    .acc_o  (acc)
  );

  orv_fold u_fold (
    .acc_i (acc),
    .size_i(size_i),
    .res_o (folded)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_o <= 1'b0;
      res_o <= '0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) res_o <= folded;
    end
  end

  // R6: one-cycle strobe, independent of data
  a_r6_strobe_follows: assert property (@(posedge clk) disable iff (rst)
    vld_i |=> vld_o);
  a_r6_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !vld_i |=> !vld_o);
  // R4: an empty predicate gives zero
  a_r4_empty_pred_zero: assert property (@(posedge clk) disable iff (rst)
    (vld_i && !(|pred_i)) |=> (res_o == '0));
  // R3: zero data gives zero
  a_r3_zero_data_zero: assert property (@(posedge clk) disable iff (rst)
    (vld_i && !(|vec_i)) |=> (res_o == '0));
  // R5: high bits cleared for narrow sizes
  a_r5_upper_zero_b: assert property (@(posedge clk) disable iff (rst)
    (vld_i && size_i == 2'd0) |=> (res_o[63:8] == '0));
  a_r5_upper_zero_h: assert property (@(posedge clk) disable iff (rst)
    (vld_i && size_i == 2'd1) |=> (res_o[63:16] == '0));
  a_r5_upper_zero_s: assert property (@(posedge clk) disable iff (rst)
    (vld_i && size_i == 2'd2) |=> (res_o[63:32] == '0));
  // R7: reset clears outputs
  a_r7_reset_clears: assert property (@(posedge clk)
    rst |=> (!vld_o && res_o == '0));
endmodule

// File: tb/test_orv_reduce.sv
module test_orv_reduce;
  localparam int unsigned VL = 256;
  localparam int unsigned NB = VL / 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          vld_i = 1'b0;
  logic [VL-1:0] vec_i = '0;
  logic [NB-1:0] pred_i = '0;
  logic [1:0]    size_i = 2'd0;
  logic          vld_o;
  logic [63:0]   res_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  orv_reduce #(.VL(VL)) i_orv_reduce (
    .clk(clk), .rst(rst), .vld_i(vld_i), .vec_i(vec_i),
    .pred_i(pred_i), .size_i(size_i), .vld_o(vld_o), .res_o(res_o)
  );

  function automatic logic [63:0] ref_or(logic [VL-1:0] d, logic [NB-1:0] p, logic [1:0] s);
    int unsigned esize = 8 << s;
    logic [63:0] m = (esize == 64) ? '1 : ((64'd1 << esize) - 64'd1);
    logic [63:0] r = '0;
    for (int e = 0; e < int'(VL / esize); e++) begin
      if (p[e * (esize / 8)]) r = r | (64'(d >> (e * esize)) & m);
    end
    return r;
  endfunction

  function automatic logic [VL-1:0] rnd_vec();
    logic [VL-1:0] v;
    for (int i = 0; i < int'(VL / 32); i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(string req, logic [VL-1:0] d, logic [NB-1:0] p, logic [1:0] s);
    logic [63:0] exp = ref_or(d, p, s);
    @(negedge clk);
    vld_i = 1'b1; vec_i = d; pred_i = p; size_i = s;
    @(negedge clk);
    vld_i = 1'b0;
    check({req, " R6 vld"}, {63'd0, vld_o}, 64'd1);
    check(req, res_o, exp);
    @(negedge clk);
    check("R6 strobe drop", {63'd0, vld_o}, 64'd0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R7: outputs while reset is held
    check("R7 vld reset", {63'd0, vld_o}, 64'd0);
    check("R7 res reset", res_o, 64'd0);
    rst = 1'b0;

    // R4: empty predicate, every size
    for (int s = 0; s < 4; s++) run_op("R4 empty pred", '1, '0, 2'(s));
    // R3: full predicate on all-ones data
    for (int s = 0; s < 4; s++) run_op("R3 full pred ones", '1, '1, 2'(s));
    // R2: only the non-leading predicate bits set, for 64-bit elements
    run_op("R2 non-lead bits", '1, {(NB/8){8'hFE}}, 2'd3);
    run_op("R2 non-lead bits h", '1, {(NB/2){2'b10}}, 2'd1);
    // R1: only the last element is active, per size
    for (int s = 0; s < 4; s++) begin
      logic [NB-1:0] p = '0;
      p[NB - (1 << s)] = 1'b1;
      run_op("R1 last element", rnd_vec(), p, 2'(s));
    end
    // R5: wide data folded into narrow sizes
    run_op("R5 byte fold", {(VL/8){8'h01}} << 8, '1, 2'd0);
    // random trials
    for (int t = 0; t < 400; t++) begin
      logic [NB-1:0] p = (t % 3 == 0) ? NB'($urandom & $urandom & $urandom) : NB'($urandom);
      run_op("R3 random", rnd_vec(), p, 2'($urandom));
    end
    // R6: back-to-back strobes
    @(negedge clk);
    vld_i = 1'b1; vec_i = '1; pred_i = '1; size_i = 2'd0;
    @(negedge clk);
    check("R6 b2b first", {63'd0, vld_o}, 64'd1);
    size_i = 2'd3;
    @(negedge clk);
    vld_i = 1'b0;
    check("R6 b2b second", {63'd0, vld_o}, 64'd1);
    check("R5 b2b result", res_o, 64'hFFFF_FFFF_FFFF_FFFF);
    // R7: reset after activity
    rst = 1'b1;
    @(negedge clk);
    check("R7 res after reset", res_o, 64'd0);
    rst = 1'b0;
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule